// File: doc/BRIEF.md
# Fast-Domain Power Sequencing Controller

This block is the fast-clock half of a power controller. It brings the main power domain up in a fixed order: first the clock is enabled, then the lifecycle reset is released, and then the system reset is released. It takes the domain back down when software asks for low power. A slow-domain controller sits beside it. That controller is outside this block and is seen here only through its invalid-state flag.

The controller is hardened against faults. In the running state, any of the following leaves the domain and drives it through a one-cycle reset-preparation step that raises a power reset request:
- a global escalation request,
- a timeout on the escalation path's heartbeat or reset,
- a low glitch on the main domain's reset,
- an error from a local hardened counter,
- a software reset request that carries the exact true code.

The state register uses sparse codes. An invalid state in either controller drives a fixed safe output pattern. That pattern holds until the block's own asynchronous reset is applied.

Multi-bit boolean inputs are 4 bits wide. True is 4'b0101 and false is 4'b1010. Every other pattern decodes as false. The asynchronous main-reset and slow-invalid inputs enter through two-flop synchronizers.

States and transitions:
- LOWPWR goes to CLKEN on a wake request.
- CLKEN goes to RSTREL, and RSTREL goes to ACTIVE, one cycle each.
- ACTIVE goes to RSTPREP on any fault, or to LOWPWR on a low-power request.
- RSTPREP goes to LOWPWR after one cycle.
- Any state goes to INVALID when the synchronized slow-invalid flag is set, and any unlisted code also becomes INVALID.
- INVALID stays until reset.

Top module: `pfsm_fast_seq`

## Requirements
- R1: After reset the state output `state_o` is LOWPWR. The state codes are LOWPWR 6'b000111, CLKEN 6'b011001, RSTREL 6'b101010, ACTIVE 6'b110100, RSTPREP 6'b111111 and INVALID 6'b000000. In LOWPWR the outputs are clk_en_o=0, lc_rst_req_o=2'b11, sys_rst_req_o=2'b11, pwr_clamp_o=0, main_pd_n_o=1, pwr_rst_req_o=0, rst_req_o=0 and fatal_alert_o=0.
- R2: A wake request in LOWPWR gives CLKEN on the next cycle (clock 1, both reset requests 2'b11). The cycle after that is RSTREL (lifecycle reset 2'b00, system reset 2'b11). The cycle after that is ACTIVE (both reset requests 2'b00, clock 1).
- R3: In ACTIVE with no fault, a low-power request gives LOWPWR on the next cycle.
- R4: In ACTIVE, a global escalation request gives RSTPREP on the next cycle. In RSTPREP, pwr_rst_req_o=1, both reset requests are 2'b11 and rst_req_o bit 3 is set. The state after RSTPREP is LOWPWR.
- R5: A main-reset low pulse of one cycle in ACTIVE gives RSTPREP on the third rising edge after it is driven. In that state rst_req_o=4'b0010.
- R6: A local counter error in ACTIVE gives RSTPREP on the next cycle with rst_req_o=4'b0100.
- R7: A software reset value of exactly 4'b0101 in ACTIVE gives RSTPREP with rst_req_o=4'b0001. All 15 other 4-bit values leave the state at ACTIVE.
- R8: The escalation timeout raises rst_req_o bit 3 and fatal_alert_o. It is reached after ESC_TIMEOUT edges without a heartbeat, or at once while the escalation-path reset input is high. Both outputs clear once heartbeats resume and that reset is released. A timeout in ACTIVE gives RSTPREP.
- R9: A slow-invalid flag gives INVALID on the third rising edge. In INVALID the outputs are pwr_clamp_o=1, main_pd_n_o=0, clk_en_o=0, lc_rst_req_o=2'b11, sys_rst_req_o=2'b11 and fatal_alert_o=1.
- R10: No input other than rst_ni leaves INVALID. Asserting rst_ni returns the block to LOWPWR.
- R11: rom_chk_dis_o is 1 only when rom_chk_dis_req_i=1 and either dft_en_i or hw_dbg_en_i equals 4'b0101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wake_req_i | input | 1 | Wake request from the slow side |
| lp_req_i | input | 1 | Low-power entry request |
| esc_req_i | input | 1 | Global escalation request |
| esc_beat_i | input | 1 | Escalation-path heartbeat pulse |
| esc_path_rst_i | input | 1 | Escalation-path reset active |
| main_rst_ni | input | 1 | Main power-domain reset, asynchronous |
| local_cnt_err_i | input | 1 | Hardened counter error |
| slow_invalid_i | input | 1 | Slow controller invalid, asynchronous |
| sw_rst_req_i | input | 4 | Software reset request, multi-bit boolean |
| dft_en_i | input | 4 | DFT enable, multi-bit boolean |
| hw_dbg_en_i | input | 4 | Hardware debug enable, multi-bit boolean |
| rom_chk_dis_req_i | input | 1 | Request to disable ROM integrity check |
| clk_en_o | output | 1 | Main-domain clock enable |
| lc_rst_req_o | output | 2 | Lifecycle reset request |
| sys_rst_req_o | output | 2 | System reset request |
| pwr_clamp_o | output | 1 | Power clamp |
| main_pd_n_o | output | 1 | Main power-down, active low |
| pwr_rst_req_o | output | 1 | Power reset request |
| rst_req_o | output | 4 | Reset cause vector (0 software, 1 glitch, 2 local, 3 escalation) |
| fatal_alert_o | output | 1 | Fatal alert |
| rom_chk_dis_o | output | 1 | ROM integrity check disable |
| state_o | output | 6 | Current state code |

## Verification
The software reset input is swept over all 16 codes from ACTIVE. This separates the single true code from the 15 codes that are malformed or false. The ROM-check gate is swept over every combination of the two enables and the request, which exposes a decoder that accepts any non-false value. Each fault source is applied alone, and the cause vector shows which one was latched. The pulse and timeout cases are timed to the exact cycle, which catches a missing or extra synchronizer stage and an off-by-one timeout limit. Holding INVALID while every other input toggles shows that the terminal state can be left only by reset.

// File: rtl/pfsm_pkg.sv
package pfsm_pkg;
    localparam int MUBI_W = 4;
    localparam logic [MUBI_W-1:0] MUBI_TRUE  = 4'b0101;
    localparam logic [MUBI_W-1:0] MUBI_FALSE = 4'b1010;

    localparam int NUM_RST  = 4;
    localparam int IDX_SW   = 0;
    localparam int IDX_GLT  = 1;
    localparam int IDX_LOC  = 2;
    localparam int IDX_ESC  = 3;

    localparam int ST_W = 6;
    // Pairwise Hamming distance is at least 3 between all codes.
    typedef enum logic [ST_W-1:0] {
        ST_LOWPWR  = 6'b000111,
        ST_CLKEN   = 6'b011001,
        ST_RSTREL  = 6'b101010,
        ST_ACTIVE  = 6'b110100,
        ST_RSTPREP = 6'b111111,
        ST_INVALID = 6'b000000
    } pfsm_state_e;

    typedef struct packed {
        logic       clk_en;
        logic [1:0] lc_rst;
        logic [1:0] sys_rst;
        logic       clamp;
        logic       pd_n;
        logic       prep;
    } pfsm_out_t;
endpackage

// File: rtl/pfsm_sync.sv
module pfsm_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] pipe_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) pipe_q[0] <= RST_VAL;
                    else         pipe_q[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) pipe_q[s] <= RST_VAL;
                    else         pipe_q[s] <= pipe_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/pfsm_mubi_dec.sv
module pfsm_mubi_dec
    import pfsm_pkg::*;
#(
    parameter int N = 1
) (
    input  logic [N-1:0][MUBI_W-1:0] mubi_i,
    output logic [N-1:0]             true_o
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_dec
            // Strict decode: only the exact true code counts.
            assign true_o[i] = (mubi_i[i] == MUBI_TRUE);
        end
    endgenerate
endmodule

// File: rtl/pfsm_esc_timer.sv
module pfsm_esc_timer #(
    parameter int ESC_TIMEOUT = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic beat_i,
    input  logic path_rst_i,
    output logic timeout_o
);
    localparam int CNT_W = $clog2(ESC_TIMEOUT + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(ESC_TIMEOUT);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (beat_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign timeout_o = (cnt_q == LIMIT) || path_rst_i;
endmodule

// File: rtl/pfsm_fast_seq.sv
module pfsm_fast_seq
    import pfsm_pkg::*;
#(
    parameter int ESC_TIMEOUT = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 wake_req_i,
    input  logic                 lp_req_i,
    input  logic                 esc_req_i,
    input  logic                 esc_beat_i,
    input  logic                 esc_path_rst_i,
    input  logic                 main_rst_ni,
    input  logic                 local_cnt_err_i,
    input  logic                 slow_invalid_i,
    input  logic [3:0]           sw_rst_req_i,
    input  logic [3:0]           dft_en_i,
    input  logic [3:0]           hw_dbg_en_i,
    input  logic                 rom_chk_dis_req_i,
    output logic                 clk_en_o,
    output logic [1:0]           lc_rst_req_o,
    output logic [1:0]           sys_rst_req_o,
    output logic                 pwr_clamp_o,
    output logic                 main_pd_n_o,
    output logic                 pwr_rst_req_o,
    output logic [3:0]           rst_req_o,
    output logic                 fatal_alert_o,
    output logic                 rom_chk_dis_o,
    output logic [5:0]           state_o
);
    localparam int NDEC = 3;

    pfsm_state_e state_q, state_d;
    pfsm_out_t   outs;
    logic [NUM_RST-1:0] cause_q, cause_d;

    logic main_rst_s, slow_inv_s, glitch, timeout;
    logic [NDEC-1:0][MUBI_W-1:0] dec_in;
    logic [NDEC-1:0]             dec_true;
    logic sw_true, dft_true, dbg_true, any_fault;

    // Input conditioning
    pfsm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_main (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (main_rst_ni),
        .q_o    (main_rst_s)
    );

    pfsm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_slow (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (slow_invalid_i),
        .q_o    (slow_inv_s)
    );

    assign dec_in = {hw_dbg_en_i, dft_en_i, sw_rst_req_i};

    pfsm_mubi_dec #(.N(NDEC)) u_dec (
        .mubi_i (dec_in),
        .true_o (dec_true)
    );

    assign sw_true  = dec_true[0];
    assign dft_true = dec_true[1];
    assign dbg_true = dec_true[2];

    pfsm_esc_timer #(.ESC_TIMEOUT(ESC_TIMEOUT)) u_esc_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .beat_i     (esc_beat_i),
        .path_rst_i (esc_path_rst_i),
        .timeout_o  (timeout)
    );

    assign glitch = ~main_rst_s;

    always_comb begin
        cause_d          = '0;
        cause_d[IDX_SW]  = sw_true;
        cause_d[IDX_GLT] = glitch;
        cause_d[IDX_LOC] = local_cnt_err_i;
        cause_d[IDX_ESC] = esc_req_i | timeout;
    end

    assign any_fault = |cause_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOWPWR:  if (wake_req_i) state_d = ST_CLKEN;
            ST_CLKEN:   state_d = ST_RSTREL;
            ST_RSTREL:  state_d = ST_ACTIVE;
            ST_ACTIVE: begin
                if (any_fault)     state_d = ST_RSTPREP;
                else if (lp_req_i) state_d = ST_LOWPWR;
            end
            ST_RSTPREP: state_d = ST_LOWPWR;
            ST_INVALID: state_d = ST_INVALID;
            default:    state_d = ST_INVALID;
        endcase
        if (slow_inv_s) state_d = ST_INVALID;
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_LOWPWR;
        else         state_q <= state_d;
    end

    // Cause latch, captured on entry to reset preparation
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cause_q <= '0;
        end else if (state_q == ST_ACTIVE && state_d == ST_RSTPREP) begin
            cause_q <= cause_d;
        end else if (state_q != ST_ACTIVE) begin
            cause_q <= '0;
        end
    end

    // Output decode
    always_comb begin
        outs = '{clk_en: 1'b0, lc_rst: 2'b11, sys_rst: 2'b11,
                 clamp: 1'b1, pd_n: 1'b0, prep: 1'b0};
        unique case (state_q)
            ST_LOWPWR: begin
                outs.clamp = 1'b0;
                outs.pd_n  = 1'b1;
            end
            ST_CLKEN: begin
                outs.clk_en = 1'b1;
                outs.clamp  = 1'b0;
                outs.pd_n   = 1'b1;
            end
            ST_RSTREL: begin
                outs.clk_en = 1'b1;
                outs.lc_rst = 2'b00;
                outs.clamp  = 1'b0;
                outs.pd_n   = 1'b1;
            end
            ST_ACTIVE: begin
                outs.clk_en  = 1'b1;
                outs.lc_rst  = 2'b00;
                outs.sys_rst = 2'b00;
                outs.clamp   = 1'b0;
                outs.pd_n    = 1'b1;
            end
            ST_RSTPREP: begin
                outs.clk_en = 1'b1;
                outs.clamp  = 1'b0;
                outs.pd_n   = 1'b1;
                outs.prep   = 1'b1;
            end
            default: begin
                // safe pattern held for INVALID and any unlisted code
            end
        endcase
    end

    assign clk_en_o      = outs.clk_en;
    assign lc_rst_req_o  = outs.lc_rst;
    assign sys_rst_req_o = outs.sys_rst;
    assign pwr_clamp_o   = outs.clamp;
    assign main_pd_n_o   = outs.pd_n;
    assign pwr_rst_req_o = outs.prep;

    always_comb begin
        rst_req_o          = outs.prep ? cause_q : '0;
        rst_req_o[IDX_ESC] = rst_req_o[IDX_ESC] | timeout;
    end

    assign fatal_alert_o = timeout | (state_q == ST_INVALID);
    assign rom_chk_dis_o = rom_chk_dis_req_i & (dft_true | dbg_true);
    assign state_o       = state_q;
endmodule

// File: rtl/pfsm_fast_seq_chk.sv
module pfsm_fast_seq_chk
    import pfsm_pkg::*;
(
    input logic       clk_i,
    input logic       rst_ni,
    input logic       esc_req_i,
    input logic       local_cnt_err_i,
    input logic       esc_path_rst_i,
    input logic [3:0] dft_en_i,
    input logic [3:0] hw_dbg_en_i,
    input logic       slow_inv_s,
    input logic       clk_en_o,
    input logic [1:0] lc_rst_req_o,
    input logic [1:0] sys_rst_req_o,
    input logic       pwr_clamp_o,
    input logic       main_pd_n_o,
    input logic       pwr_rst_req_o,
    input logic [3:0] rst_req_o,
    input logic       fatal_alert_o,
    input logic       rom_chk_dis_o,
    input logic [5:0] state_o
);
    AST_CLKEN_TO_RSTREL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == ST_CLKEN && !slow_inv_s) |=> (state_o == ST_RSTREL)); // R2

    AST_ESC_TO_PREP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == ST_ACTIVE && esc_req_i && !slow_inv_s) |=> (state_o == ST_RSTPREP)); // R4

    AST_PREP_SINGLE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == ST_RSTPREP) |=> (state_o == ST_LOWPWR || state_o == ST_INVALID)); // R4

    AST_PREP_REQUESTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == ST_RSTPREP) |-> (pwr_rst_req_o && lc_rst_req_o == 2'b11 && sys_rst_req_o == 2'b11)); // R4

    AST_LOCAL_TO_PREP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == ST_ACTIVE && local_cnt_err_i && !slow_inv_s) |=> (state_o == ST_RSTPREP)); // R6

    AST_PATH_RST_TIMEOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        esc_path_rst_i |-> (rst_req_o[IDX_ESC] && fatal_alert_o)); // R8

    AST_INVALID_SAFE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == ST_INVALID) |-> (pwr_clamp_o && !main_pd_n_o && !clk_en_o &&
                                     lc_rst_req_o == 2'b11 && sys_rst_req_o == 2'b11 && fatal_alert_o)); // R9

    AST_INVALID_TERMINAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == ST_INVALID) |=> (state_o == ST_INVALID)); // R10

    AST_ROM_DIS_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rom_chk_dis_o |-> (dft_en_i == MUBI_TRUE || hw_dbg_en_i == MUBI_TRUE)); // R11
endmodule

bind pfsm_fast_seq pfsm_fast_seq_chk u_chk (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .esc_req_i       (esc_req_i),
    .local_cnt_err_i (local_cnt_err_i),
    .esc_path_rst_i  (esc_path_rst_i),
    .dft_en_i        (dft_en_i),
    .hw_dbg_en_i     (hw_dbg_en_i),
    .slow_inv_s      (slow_inv_s),
    .clk_en_o        (clk_en_o),
    .lc_rst_req_o    (lc_rst_req_o),
    .sys_rst_req_o   (sys_rst_req_o),
    .pwr_clamp_o     (pwr_clamp_o),
    .main_pd_n_o     (main_pd_n_o),
    .pwr_rst_req_o   (pwr_rst_req_o),
    .rst_req_o       (rst_req_o),
    .fatal_alert_o   (fatal_alert_o),
    .rom_chk_dis_o   (rom_chk_dis_o),
    .state_o         (state_o)
);

// File: tb/pfsm_fast_seq_tb.sv
module pfsm_fast_seq_tb;
    localparam int TMO = 16;
    localparam logic [5:0] S_LOW = 6'b000111, S_CLK = 6'b011001, S_REL = 6'b101010,
                           S_ACT = 6'b110100, S_PREP = 6'b111111, S_INV = 6'b000000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wake = 0, lp = 0, esc = 0, beat_en = 1, path_rst = 0, main_n = 1;
    logic lerr = 0, slow_inv = 0, rom_req = 0;
    logic [3:0] sw = 4'b1010, dft = 4'b1010, dbg = 4'b1010;

    logic clk_en, clamp, pd_n, prep, fatal, rom_dis;
    logic [1:0] lc_rst, sys_rst;
    logic [3:0] rreq;
    logic [5:0] st;

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pfsm_fast_seq #(.ESC_TIMEOUT(TMO)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .wake_req_i(wake), .lp_req_i(lp),
        .esc_req_i(esc), .esc_beat_i(beat_en), .esc_path_rst_i(path_rst),
        .main_rst_ni(main_n), .local_cnt_err_i(lerr), .slow_invalid_i(slow_inv),
        .sw_rst_req_i(sw), .dft_en_i(dft), .hw_dbg_en_i(dbg), .rom_chk_dis_req_i(rom_req),
        .clk_en_o(clk_en), .lc_rst_req_o(lc_rst), .sys_rst_req_o(sys_rst),
        .pwr_clamp_o(clamp), .main_pd_n_o(pd_n), .pwr_rst_req_o(prep),
        .rst_req_o(rreq), .fatal_alert_o(fatal), .rom_chk_dis_o(rom_dis), .state_o(st)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic go_active();
        wake = 1;
        repeat (3) @(negedge clk);
        wake = 0;
        chk("R2", "reach active", st, S_ACT);
    endtask

    task automatic wait_low();
        for (int i = 0; i < 4 && st != S_LOW; i++) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1", "state", st, S_LOW);
        chk("R1", "outs", {clk_en, lc_rst, sys_rst, clamp, pd_n, prep, rreq, fatal},
            {1'b0, 2'b11, 2'b11, 1'b0, 1'b1, 1'b0, 4'b0, 1'b0});

        // R2 power-up order
        wake = 1;
        @(negedge clk); wake = 0;
        chk("R2", "clken state", st, S_CLK);
        chk("R2", "clken outs", {clk_en, lc_rst, sys_rst}, {1'b1, 2'b11, 2'b11});
        @(negedge clk);
        chk("R2", "rstrel state", st, S_REL);
        chk("R2", "rstrel outs", {clk_en, lc_rst, sys_rst}, {1'b1, 2'b00, 2'b11});
        @(negedge clk);
        chk("R2", "active state", st, S_ACT);
        chk("R2", "active outs", {clk_en, lc_rst, sys_rst, prep}, {1'b1, 2'b00, 2'b00, 1'b0});

        // R3 low power entry
        lp = 1;
        @(negedge clk); lp = 0;
        chk("R3", "lowpwr", st, S_LOW);

        // R4 global escalation
        go_active();
        esc = 1;
        @(negedge clk); esc = 0;
        chk("R4", "prep state", st, S_PREP);
        chk("R4", "prep outs", {prep, lc_rst, sys_rst, rreq}, {1'b1, 2'b11, 2'b11, 4'b1000});
        @(negedge clk);
        chk("R4", "back to lowpwr", st, S_LOW);

        // R5 main reset glitch, two sync stages then state edge
        go_active();
        main_n = 0;
        @(negedge clk); main_n = 1;
        chk("R5", "edge1", st, S_ACT);
        @(negedge clk);
        chk("R5", "edge2", st, S_ACT);
        @(negedge clk);
        chk("R5", "edge3 state", st, S_PREP);
        chk("R5", "cause", rreq, 4'b0010);
        wait_low();

        // R6 local counter error
        go_active();
        lerr = 1;
        @(negedge clk); lerr = 0;
        chk("R6", "state", st, S_PREP);
        chk("R6", "cause", rreq, 4'b0100);
        wait_low();

        // R7 exhaustive software reset code sweep
        for (int v = 0; v < 16; v++) begin
            go_active();
            sw = 4'(v);
            @(negedge clk); sw = 4'b1010;
            if (v == 5) begin
                chk("R7", "true code resets", st, S_PREP);
                chk("R7", "cause", rreq, 4'b0001);
            end else begin
                chk("R7", $sformatf("code %0h ignored", v), st, S_ACT);
            end
            if (st == S_ACT) begin
                lp = 1; @(negedge clk); lp = 0;
            end
            wait_low();
        end

        // R8 heartbeat timeout counted from the last beat
        beat_en = 0;
        begin
            int k = 0;
            while (!fatal && k < 3 * TMO) begin
                @(negedge clk);
                k++;
            end
            chk("R8", "timeout edges", k, TMO);
        end
        chk("R8", "esc bit", rreq[3], 1'b1);
        beat_en = 1;
        @(negedge clk);
        chk("R8", "cleared by beat", {fatal, rreq[3]}, 2'b00);
        path_rst = 1;
        #1 chk("R8", "path reset alert", {fatal, rreq[3]}, 2'b11);
        path_rst = 0;
        @(negedge clk);
        go_active();
        path_rst = 1;
        @(negedge clk); path_rst = 0;
        chk("R8", "timeout to prep", st, S_PREP);
        chk("R8", "cause", rreq, 4'b1000);
        wait_low();

        // R9 slow invalid
        go_active();
        slow_inv = 1;
        @(negedge clk);
        @(negedge clk);
        chk("R9", "not yet", st, S_ACT);
        @(negedge clk);
        chk("R9", "invalid state", st, S_INV);
        chk("R9", "safe outs", {clamp, pd_n, clk_en, lc_rst, sys_rst, fatal},
            {1'b1, 1'b0, 1'b0, 2'b11, 2'b11, 1'b1});

        // R10 terminal
        slow_inv = 0;
        for (int i = 0; i < 20; i++) begin
            wake = i[0]; lp = i[1]; esc = i[2]; lerr = i[3]; sw = i[0] ? 4'b0101 : 4'b1010;
            main_n = ~i[2];
            @(negedge clk);
        end
        wake = 0; lp = 0; esc = 0; lerr = 0; sw = 4'b1010; main_n = 1;
        repeat (3) @(negedge clk);
        chk("R10", "still invalid", st, S_INV);
        do_reset();
        chk("R10", "reset recovers", st, S_LOW);

        // R11 exhaustive ROM check gate
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                for (int r = 0; r < 2; r++) begin
                    dft = 4'(a); dbg = 4'(b); rom_req = r[0];
                    #1;
                    chk("R11", $sformatf("dft=%0h dbg=%0h req=%0d", a, b, r), rom_dis,
                        32'((r == 1) && (a == 5 || b == 5)));
                end
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule